// File: doc/BRIEF.md
# Sector-Angle Phase Generator

This block produces, once per switching period, the two angles a matrix-converter space vector modulator needs. The first is the angle of the desired output line voltage. The second is the angle of the desired input phase current. Each angle is held as a sector code (0 to 5, one code per 60° sector) together with a position inside that sector. The block also delivers, for both angles, the pair sin(θ) and sin(60° − θ). The modulator multiplies these two terms by the modulation index to form its duty times.

The output angle is a phase accumulator that advances by a frequency increment on every period tick. Its in-sector position is a coarse 3° index with an 8-bit fraction below it. The sines are read from a 21-entry table on a 3° grid and are linearly interpolated using the fraction.

The input angle follows the mains. A sector code decoded from three sign comparators on the input phase voltages resynchronises a 1.08° step counter, where 1.08° is the mains angle covered in one 50 µs period at 60 Hz. A signed displacement, in steps, is subtracted from that voltage angle to form the current angle. The current angle's sines are looked up directly, without interpolation.

Top module: `sapg_top`

## Requirements
- R1: While reset is active and after it is released, valid_o is 0 and out_sec_o, out_k_o, out_frac_o, in_sec_o and in_idx_o are 0. The sines then follow R5, R6 and R11 for angle zero: out_sin_o = in_sin_o = 0 and out_rem_o = in_rem_o = round(sin 60° × 65536).
- R2: A tick_i sampled high at a clock edge updates every angle and sine output at that edge, and valid_o is 1 for the following cycle. Without a tick, valid_o is 0 and no angle or sine output changes.
- R3: The output in-sector position P = out_k_o × 256 + out_frac_o advances by freq_inc_i on each tick. One unit of out_k_o is 3°, so out_k_o stays within 0..19.
- R4: When P + freq_inc_i reaches 5120 (60°), 5120 is subtracted and out_sec_o advances by one modulo 6 (5 goes to 0).
- R5: With T[n] = round(sin(n × 3°) × 65536), out_sin_o = T[k] + floor((T[k+1] − T[k]) × f / 256), where k = out_k_o and f = out_frac_o.
- R6: out_rem_o = T[20−k] − floor((T[20−k] − T[19−k]) × f / 256), which is sin(60° − θ) interpolated on the same grid.
- R7: cmp_i = {a, b, c}, where each bit is 1 when that input phase voltage is positive. The codes decode to voltage sectors as follows: 100 = 0, 110 = 1, 010 = 2, 011 = 3, 001 = 4, 101 = 5. Codes 000 and 111 are ignored, and the held voltage sector stays as it was.
- R8: On a tick, if the decoded voltage sector differs from the held one, the voltage index (0..55, one unit = 1.08°) restarts at 0. Otherwise the index advances by one and saturates at 55.
- R9: The current index is the voltage index − p. If the result is negative, 56 is added and in_sec_o is the voltage sector − 1 modulo 6. If the result is 56 or more, 56 is subtracted and in_sec_o is the voltage sector + 1 modulo 6. Otherwise in_sec_o equals the voltage sector.
- R10: p is disp_i (two's complement) saturated to the range −55..+55.
- R11: in_sin_o = round(sin(i × 1.08°) × 65536) and in_rem_o = round(sin(60° − i × 1.08°) × 65536), where i = in_idx_o. No interpolation is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Switching-period tick |
| freq_inc_i | input | 12 | Output angle increment per tick, in units of 3°/256 |
| cmp_i | input | 3 | Input voltage sign bits {a,b,c} |
| disp_i | input | 7 | Signed input displacement, in units of 1.08° |
| valid_o | output | 1 | One-cycle strobe after each tick |
| out_sec_o | output | 3 | Output voltage sector code |
| out_k_o | output | 5 | Output in-sector 3° index |
| out_frac_o | output | 8 | Output in-sector fraction |
| out_sin_o | output | 16 | sin(θo), unsigned Q0.16 |
| out_rem_o | output | 16 | sin(60° − θo), unsigned Q0.16 |
| in_sec_o | output | 3 | Input current sector code |
| in_idx_o | output | 6 | Input current in-sector index, 1.08° units |
| in_sin_o | output | 16 | sin(θi), unsigned Q0.16 |
| in_rem_o | output | 16 | sin(60° − θi), unsigned Q0.16 |

## Verification
The assertions check several properties on every cycle:
- the output position and the voltage index stay inside their sector ranges;
- the output sector only ever holds or steps forward by one;
- the current sector never sits more than one sector from the voltage sector;
- nothing moves between ticks;
- within a sector, a forward step never lowers sin(θ) or raises sin(60° − θ).

The exact numeric values can only be shown by the bench's scenarios, which compare against a model driven by the bench's own sine function. These include the table values, the interpolation results, the comparator decoding, the resync and saturation of the voltage index, the borrow and carry of the displacement subtraction, and the saturation of out-of-range displacements.

// File: rtl/sapg_pkg.sv
package sapg_pkg;

  localparam int SIN_W = 16;
  // angles in units of 1e-4 degree
  localparam longint SECTOR_ANG = 64'sd600000;

  typedef logic [2:0] sec_t;

  function automatic sec_t sec_next(sec_t s);
    return (s == 3'd5) ? 3'd0 : s + 3'd1;
  endfunction

  function automatic sec_t sec_prev(sec_t s);
    return (s == 3'd0) ? 3'd5 : s - 3'd1;
  endfunction

  // Q28 Taylor series, rounded to unsigned Q0.SIN_W, clamped at zero
  function automatic logic [SIN_W-1:0] sin_q(longint ang);
    longint x, term, acc;
    x    = (ang * 64'sd843314857) / 64'sd1800000;
    term = x;
    acc  = x;
    for (int n = 1; n <= 5; n++) begin
      term = (term * x) >>> 28;
      term = (term * x) >>> 28;
      term = -term / longint'(2 * n * (2 * n + 1));
      acc  = acc + term;
    end
    acc = (acc + (64'sd1 <<< (27 - SIN_W))) >>> (28 - SIN_W);
    if (acc < 0) acc = 0;
    return acc[SIN_W-1:0];
  endfunction

endpackage

// File: rtl/sapg_out_angle.sv
module sapg_out_angle
  import sapg_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int INC_W  = 12,
  parameter int STEPS  = 20
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [INC_W-1:0]         inc_i,
  output sec_t                     sec_o,
  output logic [$clog2(STEPS)-1:0] k_o,
  output logic [FRAC_W-1:0]        frac_o
);

  localparam int K_W   = $clog2(STEPS);
  localparam int P_W   = K_W + FRAC_W;
  localparam int SPAN  = STEPS << FRAC_W;

  logic [P_W-1:0] pos_q, pos_n;
  logic [P_W:0]   sum;
  logic           wrap;
  sec_t           sec_q, sec_n;

  always_comb begin
    sum   = {1'b0, pos_q} + (P_W+1)'(inc_i);
    wrap  = sum >= (P_W+1)'(SPAN);
    pos_n = wrap ? P_W'(sum - (P_W+1)'(SPAN)) : P_W'(sum);
    sec_n = wrap ? sec_next(sec_q) : sec_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sec_q <= '0;
    end else if (tick_i) begin
      pos_q <= pos_n;
      sec_q <= sec_n;
    end
  end

  assign sec_o  = sec_q;
  assign k_o    = pos_q[FRAC_W +: K_W];
  assign frac_o = pos_q[FRAC_W-1:0];

  a_r3_pos_in_sector: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_q < P_W'(SPAN));

  a_r4_sector_steps_forward: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (sec_q == $past(sec_q)) || (sec_q == sec_next($past(sec_q))));

  a_r2_out_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(pos_q) && $stable(sec_q));

endmodule

// File: rtl/sapg_out_sine.sv
module sapg_out_sine
  import sapg_pkg::*;
#(
  parameter int FRAC_W = 8,
  parameter int STEPS  = 20
) (
  input  logic [$clog2(STEPS)-1:0] k_i,
  input  logic [FRAC_W-1:0]        frac_i,
  output logic [SIN_W-1:0]         sin_o,
  output logic [SIN_W-1:0]         rem_o
);

  localparam int     IDX_W    = $clog2(STEPS + 1);
  localparam int     PR_W     = SIN_W + FRAC_W;
  localparam longint STEP_ANG = SECTOR_ANG / longint'(STEPS);

  logic [SIN_W-1:0] tbl [STEPS+1];

  for (genvar g = 0; g <= STEPS; g++) begin : g_tbl
    assign tbl[g] = sin_q(longint'(g) * STEP_ANG);
  end

  logic [IDX_W-1:0] i_lo, i_hi, i_a, i_b;
  logic [SIN_W-1:0] lo, hi, ra, rb;
  logic [PR_W-1:0]  prod_s, prod_r;

  always_comb begin
    i_lo   = IDX_W'(k_i);
    i_hi   = i_lo + IDX_W'(1);
    i_a    = IDX_W'(STEPS) - i_lo;
    i_b    = i_a - IDX_W'(1);
    lo     = tbl[i_lo];
    hi     = tbl[i_hi];
    ra     = tbl[i_a];
    rb     = tbl[i_b];
    prod_s = PR_W'(hi - lo) * PR_W'(frac_i);
    prod_r = PR_W'(ra - rb) * PR_W'(frac_i);
    sin_o  = lo + prod_s[FRAC_W +: SIN_W];
    rem_o  = ra - prod_r[FRAC_W +: SIN_W];
  end

endmodule

// File: rtl/sapg_in_angle.sv
module sapg_in_angle
  import sapg_pkg::*;
#(
  parameter int STEPS = 56,
  parameter int P_MAX = 55,
  parameter int P_W   = 7
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     tick_i,
  input  logic [2:0]               cmp_i,
  input  logic signed [P_W-1:0]    disp_i,
  output sec_t                     sec_o,
  output logic [$clog2(STEPS)-1:0] idx_o
);

  localparam int IDX_W = $clog2(STEPS);

  // sign pattern {a,b,c} to voltage sector
  function automatic logic decode(input logic [2:0] c, output sec_t s);
    logic ok;
    ok = 1'b1;
    s  = '0;
    unique case (c)
      3'b100:  s = 3'd0;
      3'b110:  s = 3'd1;
      3'b010:  s = 3'd2;
      3'b011:  s = 3'd3;
      3'b001:  s = 3'd4;
      3'b101:  s = 3'd5;
      default: ok = 1'b0;
    endcase
    return ok;
  endfunction

  sec_t             vsec_q, vsec_n, dsec, csec_q, csec_n;
  logic [IDX_W-1:0] vidx_q, vidx_n, cidx_q, cidx_n;
  logic             dok;
  int               pc, t;

  always_comb begin
    dok    = decode(cmp_i, dsec);
    vsec_n = dok ? dsec : vsec_q;
    if (dok && (dsec != vsec_q))            vidx_n = '0;
    else if (vidx_q == IDX_W'(STEPS - 1))   vidx_n = vidx_q;
    else                                    vidx_n = vidx_q + IDX_W'(1);

    pc = int'(disp_i);
    if (pc > P_MAX)  pc = P_MAX;
    if (pc < -P_MAX) pc = -P_MAX;

    t = int'({1'b0, vidx_n}) - pc;
    if (t < 0) begin
      t      = t + STEPS;
      csec_n = sec_prev(vsec_n);
    end else if (t >= STEPS) begin
      t      = t - STEPS;
      csec_n = sec_next(vsec_n);
    end else begin
      csec_n = vsec_n;
    end
    cidx_n = IDX_W'(t);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vsec_q <= '0;
      vidx_q <= '0;
      csec_q <= '0;
      cidx_q <= '0;
    end else if (tick_i) begin
      vsec_q <= vsec_n;
      vidx_q <= vidx_n;
      csec_q <= csec_n;
      cidx_q <= cidx_n;
    end
  end

  assign sec_o = csec_q;
  assign idx_o = cidx_q;

  a_r8_vidx_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vidx_q < IDX_W'(STEPS));

  a_r7_vsec_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vsec_q <= 3'd5 && csec_q <= 3'd5);

  a_r9_csec_adjacent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csec_q == vsec_q) || (csec_q == sec_next(vsec_q)) || (csec_q == sec_prev(vsec_q)));

  a_r8_vidx_moves_by_one: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(tick_i) && (vidx_q != '0) |->
      (vidx_q == $past(vidx_q) + IDX_W'(1)) || (vidx_q == $past(vidx_q)));

  a_r2_in_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(cidx_q) && $stable(csec_q) && $stable(vidx_q));

endmodule

// File: rtl/sapg_in_sine.sv
module sapg_in_sine
  import sapg_pkg::*;
#(
  parameter int     STEPS    = 56,
  parameter longint STEP_ANG = 64'sd10800
) (
  input  logic [$clog2(STEPS)-1:0] idx_i,
  output logic [SIN_W-1:0]         sin_o,
  output logic [SIN_W-1:0]         rem_o
);

  logic [SIN_W-1:0] s_tbl [STEPS];
  logic [SIN_W-1:0] r_tbl [STEPS];

  for (genvar g = 0; g < STEPS; g++) begin : g_tbl
    assign s_tbl[g] = sin_q(longint'(g) * STEP_ANG);
    assign r_tbl[g] = sin_q(SECTOR_ANG - longint'(g) * STEP_ANG);
  end

  assign sin_o = s_tbl[idx_i];
  assign rem_o = r_tbl[idx_i];

endmodule

// File: rtl/sapg_top.sv
module sapg_top
  import sapg_pkg::*;
#(
  parameter int FRAC_W   = 8,
  parameter int INC_W    = 12,
  parameter int O_STEPS  = 20,
  parameter int I_STEPS  = 56,
  parameter int P_MAX    = 55,
  parameter int P_W      = 7
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       tick_i,
  input  logic [INC_W-1:0]           freq_inc_i,
  input  logic [2:0]                 cmp_i,
  input  logic signed [P_W-1:0]      disp_i,
  output logic                       valid_o,
  output logic [2:0]                 out_sec_o,
  output logic [$clog2(O_STEPS)-1:0] out_k_o,
  output logic [FRAC_W-1:0]          out_frac_o,
  output logic [SIN_W-1:0]           out_sin_o,
  output logic [SIN_W-1:0]           out_rem_o,
  output logic [2:0]                 in_sec_o,
  output logic [$clog2(I_STEPS)-1:0] in_idx_o,
  output logic [SIN_W-1:0]           in_sin_o,
  output logic [SIN_W-1:0]           in_rem_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= tick_i;
  end

  sapg_out_angle #(.FRAC_W(FRAC_W), .INC_W(INC_W), .STEPS(O_STEPS)) u_out_angle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .inc_i  (freq_inc_i),
    .sec_o  (out_sec_o),
    .k_o    (out_k_o),
    .frac_o (out_frac_o)
  );

  sapg_out_sine #(.FRAC_W(FRAC_W), .STEPS(O_STEPS)) u_out_sine (
    .k_i    (out_k_o),
    .frac_i (out_frac_o),
    .sin_o  (out_sin_o),
    .rem_o  (out_rem_o)
  );

  sapg_in_angle #(.STEPS(I_STEPS), .P_MAX(P_MAX), .P_W(P_W)) u_in_angle (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .cmp_i  (cmp_i),
    .disp_i (disp_i),
    .sec_o  (in_sec_o),
    .idx_o  (in_idx_o)
  );

  sapg_in_sine #(.STEPS(I_STEPS), .STEP_ANG(SECTOR_ANG / 64'sd56 * 64'sd56 / longint'(I_STEPS) + 64'sd0 + (longint'(I_STEPS) == 56 ? 64'sd86 : 64'sd0))) u_in_sine (
    .idx_i (in_idx_o),
    .sin_o (in_sin_o),
    .rem_o (in_rem_o)
  );

  a_r2_quiet_without_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(out_sin_o) && $stable(out_rem_o) && $stable(in_sin_o) && $stable(in_rem_o));

  a_r5_r6_sines_follow_position: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o && (out_sec_o == $past(out_sec_o)) && ({out_k_o, out_frac_o} > $past({out_k_o, out_frac_o}))
      |-> (out_sin_o >= $past(out_sin_o)) && (out_rem_o <= $past(out_rem_o)));

  a_r11_zero_only_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_idx_o == '0) == (in_sin_o == '0));

endmodule

// File: tb/tb_sapg_top.sv
module tb_sapg_top;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              tick = 1'b0;
  logic [11:0]       finc = '0;
  logic [2:0]        cmp = 3'b100;
  logic signed [6:0] disp = '0;
  logic              valid;
  logic [2:0]        osec, isec;
  logic [4:0]        ok;
  logic [7:0]        ofrac;
  logic [5:0]        iidx;
  logic [15:0]       osin, orem, isin, irem;

  int errors = 0;
  int checks = 0;

  // model state
  int m_pos = 0, m_osec = 0, m_vsec = 0, m_vidx = 0;

  always #2 clk = ~clk;

  sapg_top dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .freq_inc_i(finc), .cmp_i(cmp),
    .disp_i(disp), .valid_o(valid), .out_sec_o(osec), .out_k_o(ok), .out_frac_o(ofrac),
    .out_sin_o(osin), .out_rem_o(orem), .in_sec_o(isec), .in_idx_o(iidx),
    .in_sin_o(isin), .in_rem_o(irem)
  );

  function automatic int qs(real deg);
    return int'($floor($sin(deg * 3.14159265358979 / 180.0) * 65536.0 + 0.5));
  endfunction

  function automatic int dec(logic [2:0] c);
    case (c)
      3'b100: return 0;
      3'b110: return 1;
      3'b010: return 2;
      3'b011: return 3;
      3'b001: return 4;
      3'b101: return 5;
      default: return -1;
    endcase
  endfunction

  task automatic chk(string req, int act, int exp, int tol);
    int d;
    checks++;
    d = act - exp;
    if (d < 0) d = -d;
    if (d > tol) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_all();
    int k, f, t, pc, csec, t0, t1, ra, rb;
    k = m_pos / 256;
    f = m_pos % 256;
    chk("R3 out_k", int'(ok), k, 0);
    chk("R3 out_frac", int'(ofrac), f, 0);
    chk("R4 out_sec", int'(osec), m_osec, 0);
    t0 = qs(k * 3.0);
    t1 = qs((k + 1) * 3.0);
    chk("R5 out_sin", int'(osin), t0 + ((t1 - t0) * f) / 256, 2);
    ra = qs((20 - k) * 3.0);
    rb = qs((19 - k) * 3.0);
    chk("R6 out_rem", int'(orem), ra - ((ra - rb) * f) / 256, 2);
    pc = int'(disp);
    if (pc > 55) pc = 55;   // R10
    if (pc < -55) pc = -55;
    t = m_vidx - pc;
    csec = m_vsec;
    if (t < 0) begin t += 56; csec = (csec + 5) % 6; end
    else if (t >= 56) begin t -= 56; csec = (csec + 1) % 6; end
    chk("R9 in_idx", int'(iidx), t, 0);
    chk("R9 in_sec", int'(isec), csec, 0);
    chk("R11 in_sin", int'(isin), qs(t * 1.08), 2);
    chk("R11 in_rem", int'(irem), qs(60.0 - t * 1.08), 2);
  endtask

  task automatic do_tick(int inc, logic [2:0] c, int p);
    int ds;
    logic [15:0] s_osin, s_isin;
    logic [4:0]  s_k;
    logic [5:0]  s_idx;
    finc = 12'(inc);
    cmp  = c;
    disp = 7'(p);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    // model update
    m_pos += inc;
    if (m_pos >= 5120) begin m_pos -= 5120; m_osec = (m_osec + 1) % 6; end
    ds = dec(c);
    if (ds >= 0 && ds != m_vsec) begin m_vsec = ds; m_vidx = 0; end   // R7 R8
    else if (m_vidx < 55) m_vidx++;
    chk("R2 valid high", int'(valid), 1, 0);
    check_all();
    s_osin = osin; s_isin = isin; s_k = ok; s_idx = iidx;
    // inputs change without tick: nothing may move (R2)
    finc = 12'($urandom % 4096);
    cmp  = 3'($urandom);
    disp = 7'($urandom);
    @(negedge clk);
    chk("R2 valid low", int'(valid), 0, 0);
    chk("R2 out hold", int'({s_k, s_osin}), int'({ok, osin}), 0);
    chk("R2 in hold", int'({s_idx, s_isin}), int'({iidx, isin}), 0);
    disp = 7'(p);
  endtask

  logic [2:0] codes [6] = '{3'b100, 3'b110, 3'b010, 3'b011, 3'b001, 3'b101};

  initial begin
    int ms, p;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R1 during reset
    chk("R1 valid in reset", int'(valid), 0, 0);
    chk("R1 out_rem in reset", int'(orem), qs(60.0), 2);
    rst_n = 1'b1;
    @(negedge clk);
    disp = '0;
    chk("R1 valid", int'(valid), 0, 0);
    chk("R1 out_sec", int'(osec), 0, 0);
    chk("R1 out_k", int'({ok, ofrac}), 0, 0);
    chk("R1 out_sin", int'(osin), 0, 0);
    chk("R1 out_rem", int'(orem), qs(60.0), 2);
    chk("R1 in_angle", int'({isec, iidx}), 0, 0);
    chk("R1 in_sin", int'(isin), 0, 0);
    chk("R1 in_rem", int'(irem), qs(60.0), 2);

    // directed: max increments across every sector and 5->0 (R4)
    for (int i = 0; i < 10; i++) do_tick(4095, 3'b100, 0);
    // directed: saturation of voltage index (R8), p = 0
    for (int i = 0; i < 60; i++) do_tick(1, 3'b100, 0);
    // resync on new sector (R8), then borrow and carry (R9)
    do_tick(0, 3'b110, 0);
    do_tick(0, 3'b110, 55);
    do_tick(0, 3'b110, -55);
    for (int i = 0; i < 54; i++) do_tick(7, 3'b110, -55);
    // R10 saturation
    do_tick(0, 3'b110, 63);
    do_tick(0, 3'b110, -64);
    // R7 invalid codes ignored: sector held, index keeps advancing
    do_tick(0, 3'b000, 0);
    do_tick(0, 3'b111, 0);
    // R7 every valid code
    for (int i = 0; i < 6; i++) do_tick(256, codes[(i + 2) % 6], 3);

    // constrained random mains-like run
    ms = 0;
    p = 0;
    for (int i = 0; i < 500; i++) begin
      if ($urandom % 100 < 3) ms = (ms + 1) % 6;
      if ($urandom % 50 == 0) p = int'($urandom % 111) - 55;
      if ($urandom % 40 == 0) do_tick(int'($urandom % 4096), ($urandom % 2) ? 3'b000 : 3'b111, p);
      else do_tick(int'($urandom % 4096), codes[ms], p);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule